// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short record of finished transmissions for the host. Each time the transmit engine finishes a frame, it pulses a completion strobe together with four outcome flags: interrupt wanted, jabber, underrun and collision limit. The block turns these into one status byte and stores it. The host reads the oldest stored byte at a status port. Any write to that port discards the byte and brings the next one forward. The port reads zero when nothing is stored.

The store holds a small, fixed number of bytes. A completion that arrives when every slot is full is thrown away, and the newest stored byte is marked to show that reports were lost. The block also raises a one-cycle event when it stores a byte that needs the host's attention.

Jabber and underrun are fatal errors, and so is a transmit FIFO overrun. Each of them locks the transmitter off. A FIFO overrun also raises an adapter failure flag. A transmit reset or a global reset empties the store and releases both the lockout and the failure flag.

Top module: `tx_status_stack`

## Requirements
- R1: After global reset, the status port reads 0x00, and `tx_disable`, `adapter_fail` and `txc_event` are all 0.
- R2: A completion stores one byte: bit 7 = 1, bit 6 = interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = 0, bits 1..0 = 0. The byte is visible the cycle after the strobe if it is the oldest entry.
- R3: Entries are read out oldest first. A write to the status port removes the oldest entry. Up to DEPTH entries (default 4) are held.
- R4: A write to the port while the store is empty has no effect. An empty store reads 0x00.
- R5: A completion that arrives while the store is full, with no removal in the same cycle, is discarded. Bit 2 is then set in the newest stored entry, and the other entries are unchanged.
- R6: A removal and a completion in the same cycle on a full store both take effect. No overflow mark is set.
- R7: `txc_event` is high for one cycle, the cycle after a stored completion that has any of bits 6..3 set. A discarded completion does not raise it.
- R8: A completion with jabber or underrun sets `tx_disable` from the next cycle. It stays set until a transmit reset or a global reset, even if the completion itself is discarded.
- R9: A pulse on `fifo_overrun` sets both `adapter_fail` and `tx_disable` from the next cycle, until a transmit reset or a global reset.
- R10: `tx_reset` empties the store and clears `tx_disable` and `adapter_fail` on the next cycle. It overrides a completion, a removal or an overrun in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, synchronous |
| tx_reset | input | 1 | Transmit reset, synchronous |
| done_valid | input | 1 | Completion strobe from the transmit engine |
| done_intr | input | 1 | Interrupt on success requested |
| done_jabber | input | 1 | Jabber error |
| done_underrun | input | 1 | Underrun error |
| done_maxcoll | input | 1 | Collision limit reached |
| fifo_overrun | input | 1 | Transmit FIFO overrun pulse |
| stat_wr | input | 1 | Host write to the status port (removes the oldest entry) |
| stat_rd_data | output | 8 | Oldest stored status byte, or 0x00 when the store is empty |
| txc_event | output | 1 | Transmit-complete event pulse |
| tx_disable | output | 1 | Transmitter lockout |
| adapter_fail | output | 1 | Adapter failure flag |

## Verification
The assertions assume that the outcome flags matter only while `done_valid` is high. They also assume that `tx_reset` is a synchronous level that the block samples on the clock edge. The bench changes every input at the falling edge, so each strobe lasts exactly one clock cycle. It raises outcome flags only together with `done_valid` and clears them afterwards. It drives `tx_reset` only between other operations, except in the one case that deliberately tests its override of a same-cycle completion.

// File: rtl/tx_status_stack.sv
module tx_status_stack #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_reset,
  input  logic       done_valid,
  input  logic       done_intr,
  input  logic       done_jabber,
  input  logic       done_underrun,
  input  logic       done_maxcoll,
  input  logic       fifo_overrun,
  input  logic       stat_wr,
  output logic [7:0] stat_rd_data,
  output logic       txc_event,
  output logic       tx_disable,
  output logic       adapter_fail
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    slot [DEPTH];
  logic [7:0]    slot_nxt [DEPTH];
  logic [CW-1:0] cnt;

  wire empty = (cnt == '0);
  wire full  = (cnt == CW'(DEPTH));
  wire pop   = stat_wr && !empty;
  wire push  = done_valid && (!full || pop);
  wire drop  = done_valid && full && !pop;
  wire fatal = done_valid && (done_jabber || done_underrun);
  wire [7:0] entry = {1'b1, done_intr, done_jabber, done_underrun, done_maxcoll, 3'b000};
  wire [CW-1:0] wr_idx = pop ? cnt - CW'(1) : cnt;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (pop) slot_nxt[i] = (i < DEPTH - 1) ? slot[(i + 1) % DEPTH] : 8'h00;
      else     slot_nxt[i] = slot[i];
      if (push && wr_idx == CW'(i)) slot_nxt[i] = entry;
      if (drop && i == DEPTH - 1)   slot_nxt[i][2] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tx_reset) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= 8'h00;
      cnt          <= '0;
      txc_event    <= 1'b0;
      tx_disable   <= 1'b0;
      adapter_fail <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= slot_nxt[i];
      cnt          <= cnt + CW'(push) - CW'(pop);
      txc_event    <= push && (done_intr || done_jabber || done_underrun || done_maxcoll);
      tx_disable   <= tx_disable || fatal || fifo_overrun;
      adapter_fail <= adapter_fail || fifo_overrun;
    end
  end

  assign stat_rd_data = slot[0];
endmodule

// File: rtl/tx_status_stack_chk.sv
module tx_status_stack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_reset,
  input logic       done_valid,
  input logic       done_jabber,
  input logic       done_underrun,
  input logic       fifo_overrun,
  input logic [7:0] stat_rd_data,
  input logic       txc_event,
  input logic       tx_disable,
  input logic       adapter_fail
);
  assert_entry_format_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_data != 8'h00) |-> (stat_rd_data[7] && stat_rd_data[1:0] == 2'b00));

  assert_event_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    txc_event |-> $past(done_valid));

  assert_fatal_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && (done_jabber || done_underrun) && !tx_reset) |=> tx_disable);

  assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_disable && !tx_reset) |=> tx_disable);

  assert_overrun_fails_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_overrun && !tx_reset) |=> (adapter_fail && tx_disable));

  assert_fail_implies_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    adapter_fail |-> tx_disable);

  assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> (!tx_disable && !adapter_fail && stat_rd_data == 8'h00 && !txc_event));
endmodule

bind tx_status_stack tx_status_stack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_reset(tx_reset), .done_valid(done_valid),
  .done_jabber(done_jabber), .done_underrun(done_underrun),
  .fifo_overrun(fifo_overrun), .stat_rd_data(stat_rd_data),
  .txc_event(txc_event), .tx_disable(tx_disable), .adapter_fail(adapter_fail)
);

// File: tb/sim_tx_status_stack.sv
module sim_tx_status_stack;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0, tx_reset = 0, done_valid = 0, done_intr = 0;
  logic done_jabber = 0, done_underrun = 0, done_maxcoll = 0, fifo_overrun = 0, stat_wr = 0;
  logic [7:0] stat_rd_data;
  logic txc_event, tx_disable, adapter_fail;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] q[$];
  bit exp_dis = 0, exp_fail = 0;

  always #2 clk = ~clk;

  tx_status_stack #(.DEPTH(DEPTH)) u0 (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] top();
    return (q.size() > 0) ? q[0] : 8'h00;
  endfunction

  task automatic check_all(string req);
    chk(req, stat_rd_data, top());
    chk(req, {7'b0, tx_disable}, {7'b0, exp_dis});
    chk(req, {7'b0, adapter_fail}, {7'b0, exp_fail});
  endtask

  task automatic complete(bit ir, bit jb, bit un, bit mc, bit pop, string req);
    logic [7:0] e;
    logic [7:0] last;
    bit acc;
    e = {1'b1, ir, jb, un, mc, 3'b000};
    acc = (q.size() < DEPTH) || (pop && q.size() > 0);
    @(negedge clk);
    done_valid = 1; done_intr = ir; done_jabber = jb; done_underrun = un; done_maxcoll = mc;
    stat_wr = pop;
    @(negedge clk);
    done_valid = 0; done_intr = 0; done_jabber = 0; done_underrun = 0; done_maxcoll = 0;
    stat_wr = 0;
    if (pop && q.size() > 0) void'(q.pop_front());
    if (acc) q.push_back(e);
    else begin
      last = q[q.size() - 1];
      last[2] = 1'b1;
      q[q.size() - 1] = last;
    end
    if (jb || un) exp_dis = 1;
    chk(req, {7'b0, txc_event}, {7'b0, acc && (ir || jb || un || mc)});
    check_all(req);
  endtask

  task automatic pop_check(string req);
    chk(req, stat_rd_data, top());
    @(negedge clk); stat_wr = 1;
    @(negedge clk); stat_wr = 0;
    if (q.size() > 0) void'(q.pop_front());
    check_all(req);
  endtask

  task automatic do_tx_reset(string req);
    @(negedge clk); tx_reset = 1;
    @(negedge clk); tx_reset = 0;
    q.delete(); exp_dis = 0; exp_fail = 0;
    check_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");
    chk("R1", {7'b0, txc_event}, 8'h00);

    pop_check("R4");
    complete(0, 0, 0, 0, 0, "R2");
    complete(1, 0, 0, 0, 0, "R7");
    complete(0, 0, 0, 1, 0, "R2");
    pop_check("R3"); pop_check("R3"); pop_check("R3");
    pop_check("R4");

    complete(1, 0, 0, 0, 0, "R3");
    complete(0, 0, 0, 1, 0, "R3");
    complete(0, 0, 0, 0, 0, "R3");
    complete(1, 0, 0, 1, 0, "R3");
    complete(1, 0, 0, 1, 0, "R5");
    complete(0, 0, 0, 0, 0, "R5");
    complete(0, 0, 0, 0, 1, "R6");
    for (int i = 0; i < DEPTH; i++) pop_check("R5");
    pop_check("R4");

    complete(0, 1, 0, 0, 0, "R8");
    repeat (10) @(negedge clk);
    check_all("R8");
    do_tx_reset("R10");

    for (int i = 0; i < DEPTH; i++) complete(0, 0, 0, 0, 0, "R3");
    complete(0, 0, 1, 0, 0, "R8");
    do_tx_reset("R10");

    @(negedge clk); fifo_overrun = 1;
    @(negedge clk); fifo_overrun = 0;
    exp_dis = 1; exp_fail = 1;
    check_all("R9");
    repeat (5) @(negedge clk);
    check_all("R9");
    do_tx_reset("R10");

    @(negedge clk);
    done_valid = 1; done_underrun = 1; fifo_overrun = 1; tx_reset = 1;
    @(negedge clk);
    done_valid = 0; done_underrun = 0; fifo_overrun = 0; tx_reset = 0;
    check_all("R10");
    chk("R10", {7'b0, txc_event}, 8'h00);

    complete(1, 0, 0, 0, 0, "R2");
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    q.delete();
    check_all("R1");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule